// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked one-shot. A qualified trigger event drives the `pulse` output high for a set number of clock cycles, and `pulse_n` carries the complement of `pulse`. The pulse length is read from the `width` input at the moment a trigger is accepted, so the length can change from one pulse to the next. Three events count as a trigger: a falling edge on the active-low `fall_in`, a rising edge on the active-high `rise_in`, and the release of the active-low `clr_n`. Each of these is accepted only when the other two inputs are at their enabling levels.

A trigger that arrives while a pulse is running starts the timing again. The pulse then ends a full programmed period after the last trigger. Driving `clr_n` low ends a running pulse and blocks every trigger for as long as it stays low. The inputs are expected to be synchronous to `clk` already. A synchronous active-high `rst`, which is separate from the functional clear, returns the block to idle.

Top module: `oneshot_retrig`

## Requirements
- R1: While `rst` is high and after it is released, with no trigger given, `pulse` is 0 and `pulse_n` is 1.
- R2: A high-to-low change on `fall_in` between two clock edges is a trigger when `rise_in` is 1 and `clr_n` is 1.
- R3: A low-to-high change on `rise_in` is a trigger when `fall_in` is 0 and `clr_n` is 1.
- R4: A low-to-high change on `clr_n` is a trigger when `fall_in` is 0 and `rise_in` is 1.
- R5: While `fall_in` is 1, or while `rise_in` is 0, no trigger is accepted and `pulse` stays as it was.
- R6: A trigger accepted while `pulse` is 1 restarts the timing. `pulse` then stays 1 for exactly `width` cycles counted from that trigger.
- R7: `clr_n` at 0 on a clock edge drives `pulse` to 0 after that edge, even in the middle of a pulse.
- R8: While `clr_n` is held at 0, edges on `fall_in` or `rise_in` leave the outputs unchanged.
- R9: A `width` of 0 gives a pulse of one cycle.
- R10: `pulse` is 1 in the cycle right after the edge that accepts a trigger. This holds whatever `width` is and however far a running pulse has progressed.
- R11: Several qualifying edges seen on the same clock edge count as one trigger, giving a single pulse of `width` cycles.
- R12: When `rst` is released, this does not count as a release of `clr_n`, even if `fall_in` is 0 and `rise_in` is 1.
- R13: `pulse_n` is always the complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fall_in | input | 1 | Trigger input, acts on its falling edge |
| rise_in | input | 1 | Trigger input, acts on its rising edge |
| clr_n | input | 1 | Active-low clear; its release can trigger |
| width | input | CNT_W | Pulse length in cycles, read when a trigger is accepted |
| pulse | output | 1 | Registered one-shot output |
| pulse_n | output | 1 | Registered complement of `pulse` |

## Verification
The assertions assume that `fall_in`, `rise_in`, `clr_n` and `width` change only between clock edges and hold steady around each rising edge. The bench meets this by driving every input on the falling clock edge. The properties that follow a pulse cycle by cycle also assume that nothing but a trigger or a low clear interrupts the countdown. The stimulus changes the inputs at chosen points to cover each case: retriggers in the middle of a pulse, a clear in the middle of a pulse, edges that arrive while an input is blocking them, and edges that coincide.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Which qualified sources fired on the current clock edge
  typedef struct packed {
    logic fall_hit;
    logic rise_hit;
    logic clr_hit;
  } trig_src_t;

  function automatic logic src_any(trig_src_t s);
    return s.fall_hit | s.rise_hit | s.clr_hit;
  endfunction

  // Counter reload for a requested width; zero is promoted to one cycle
  function automatic logic [31:0] reload_of(logic [31:0] w);
    return (w == 32'd0) ? 32'd0 : w - 32'd1;
  endfunction

endpackage

// File: rtl/os_trig_qualify.sv
module os_trig_qualify
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall_in,
  input  logic rise_in,
  input  logic clr_n,
  output logic trig
);

  logic fall_q, rise_q, clr_q;
  trig_src_t src;

  // Previous-cycle copies; reset values chosen so no edge is seen after rst
  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
      rise_q <= 1'b1;
      clr_q  <= 1'b1;
    end else begin
      fall_q <= fall_in;
      rise_q <= rise_in;
      clr_q  <= clr_n;
    end
  end

  always_comb begin
    src.fall_hit = fall_q & ~fall_in & rise_in & clr_n;
    src.rise_hit = ~rise_q & rise_in & ~fall_in & clr_n;
    src.clr_hit  = ~clr_q & clr_n & ~fall_in & rise_in;
    trig         = src_any(src);
  end

  // R8
  clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> !trig);

  // R5
  fall_high_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    fall_in |-> !trig);

  // R5
  rise_low_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_in |-> !trig);

endmodule

// File: rtl/os_width_timer.sv
module os_width_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             qn
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic [31:0]      load_wide;

  always_comb begin
    load_wide = reload_of(32'(width));
    load_val  = load_wide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
      qn  <= 1'b1;
    end else if (!clr_n) begin
      cnt <= '0;
      q   <= 1'b0;
      qn  <= 1'b1;
    end else if (trig) begin
      cnt <= load_val;
      q   <= 1'b1;
      qn  <= 1'b0;
    end else if (q) begin
      if (cnt == '0) begin
        q  <= 1'b0;
        qn <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R7
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !q);

  // R10
  trig_sets_q_chk: assert property (@(posedge clk) disable iff (rst)
    (trig && clr_n) |=> q);

  // R6
  hold_during_count_chk: assert property (@(posedge clk) disable iff (rst)
    (q && cnt != '0 && clr_n) |=> q);

  // R9
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    (trig && clr_n && width == '0) |=> (cnt == '0));

endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_in,
  input  logic             rise_in,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic             pulse_n
);

  logic trig;

  os_trig_qualify u_qual (
    .clk     (clk),
    .rst     (rst),
    .fall_in (fall_in),
    .rise_in (rise_in),
    .clr_n   (clr_n),
    .trig    (trig)
  );

  os_width_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .trig  (trig),
    .width (width),
    .q     (pulse),
    .qn    (pulse_n)
  );

  // R13
  compl_out_chk: assert property (@(posedge clk) disable iff (rst)
    pulse != pulse_n);

  // R1
  idle_after_rst_chk: assert property (@(posedge clk)
    rst |=> (!pulse && pulse_n));

endmodule

// File: tb/oneshot_retrig_bench.sv
`timescale 1ns/1ps
module oneshot_retrig_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fall_in = 1'b1;
  logic             rise_in = 1'b0;
  logic             clr_n = 1'b1;
  logic [CNT_W-1:0] width = '0;
  logic             pulse, pulse_n;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oneshot_retrig #(.CNT_W(CNT_W)) u_oneshot_retrig (
    .clk(clk), .rst(rst), .fall_in(fall_in), .rise_in(rise_in),
    .clr_n(clr_n), .width(width), .pulse(pulse), .pulse_n(pulse_n)
  );

  // Behavioural reference: remaining high cycles
  int rem = 0;
  logic pf = 1'b0, pr = 1'b1, pc = 1'b1;

  always @(posedge clk) begin
    bit hit;
    if (rst) begin
      rem = 0; pf = 1'b0; pr = 1'b1; pc = 1'b1;
    end else begin
      hit = clr_n && !fall_in && rise_in && (pf || !pc);
      hit = hit || (clr_n && !fall_in && rise_in && !pr);
      if (!clr_n) rem = 0;
      else if (hit) rem = (width == 0) ? 1 : int'(width);
      else if (rem > 0) rem = rem - 1;
      pf = fall_in; pr = rise_in; pc = clr_n;
    end
    started = 1'b1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      check(tag, pulse, rem > 0);
      check("R13", pulse_n, !(rem > 0));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    @(negedge clk);
    while (pulse === 1'b1 && n < 300) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s: pulse length %0d expected %0d", req, n, exp);
    end
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    check("R1", pulse, 1'b0);
    check("R1", pulse_n, 1'b1);

    // R12: leave reset with clr_n rising and the other inputs enabling
    tag = "R12";
    fall_in = 1'b0; rise_in = 1'b1; clr_n = 1'b0;
    cyc(1);
    rst = 1'b0; clr_n = 1'b1;
    cyc(3);
    check("R12", pulse, 1'b0);

    // R2: falling edge on fall_in
    tag = "R2";
    fall_in = 1'b1; width = 8'd4;
    cyc(2);
    fall_in = 1'b0;
    cyc(1);
    check("R10", pulse, 1'b1);
    cyc(6);
    fall_in = 1'b1; width = 8'd4;
    cyc(1);
    fall_in = 1'b0;
    measure("R2", 4);

    // R3: rising edge on rise_in
    tag = "R3";
    rise_in = 1'b0; width = 8'd6;
    cyc(2);
    rise_in = 1'b1;
    measure("R3", 6);

    // R4: release of clr_n
    tag = "R4";
    clr_n = 1'b0; width = 8'd3;
    cyc(2);
    clr_n = 1'b1;
    measure("R4", 3);

    // R5: blocking levels
    tag = "R5";
    fall_in = 1'b1; rise_in = 1'b0; width = 8'd5;
    cyc(2);
    rise_in = 1'b1; cyc(2); rise_in = 1'b0; cyc(2);
    fall_in = 1'b0; cyc(2); fall_in = 1'b1; cyc(2);
    check("R5", pulse, 1'b0);

    // R6: retrigger in mid pulse
    tag = "R6";
    fall_in = 1'b0; rise_in = 1'b0; width = 8'd5;
    cyc(1);
    rise_in = 1'b1; cyc(1);
    rise_in = 1'b0; cyc(1);
    rise_in = 1'b1;
    measure("R6", 5);

    // R10: retrigger late in a long pulse with a short width
    tag = "R10";
    rise_in = 1'b0; width = 8'd10;
    cyc(1);
    rise_in = 1'b1; cyc(6);
    rise_in = 1'b0; cyc(1);
    width = 8'd2; rise_in = 1'b1;
    measure("R10", 2);

    // R7: clear in mid pulse
    tag = "R7";
    rise_in = 1'b0; width = 8'd20;
    cyc(1);
    rise_in = 1'b1; cyc(4);
    clr_n = 1'b0;
    cyc(1);
    check("R7", pulse, 1'b0);

    // R8: edges ignored while clear low
    tag = "R8";
    rise_in = 1'b0; cyc(1); rise_in = 1'b1; cyc(1);
    fall_in = 1'b1; cyc(1); fall_in = 1'b0; cyc(2);
    check("R8", pulse, 1'b0);
    fall_in = 1'b1;
    cyc(1);
    clr_n = 1'b1;
    cyc(2);
    check("R5", pulse, 1'b0);

    // R9: zero width
    tag = "R9";
    width = 8'd0; rise_in = 1'b1;
    cyc(1);
    fall_in = 1'b0;
    measure("R9", 1);

    // R11: three qualifying edges at once
    tag = "R11";
    fall_in = 1'b1; rise_in = 1'b0; clr_n = 1'b0; width = 8'd3;
    cyc(2);
    fall_in = 1'b0; rise_in = 1'b1; clr_n = 1'b1;
    measure("R11", 3);
    cyc(3);
    check("R11", pulse, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule